// File: doc/BRIEF.md
# Reset Delay Sequencer

This block keeps a microcontroller core in reset after any reset event until a fixed number of ticks from a free-running internal oscillator has elapsed. Power-on reset, an active-low external clear pin, a watchdog timeout, a wake-up-on-pin-change pulse and a brown-out comparator flag all start a reset sequence. The core is released only when the tick counter reaches the delay selected for the current situation.

The delay depends on the oscillator mode and on whether a sequence has already completed since power-on. The first sequence after power-on always uses the long delay. Later sequences use the short delay only in external RC mode. A brown-out holds the block in reset with the counter frozen at zero, and the full delay runs again once the supply recovers. Brown-out detection is gated by an enable bit that the block holds. Software sets this bit through a write strobe, and every power-on reset clears it.

The block also reports the most recent reset cause as a 3-bit code.

Top module: `rst_delay_seq`

## Requirements
- R1: `core_rst_o` stays high while the timer is counting. It goes low at the clock edge that counts the final tick of the selected delay.
- R2: The first sequence after power-on lasts LONG_TICKS ticks in every oscillator mode, including RC mode (`osc_mode_i` = 3).
- R3: Every sequence after the first completed one lasts LONG_TICKS ticks in modes 0, 1 and 2, and SHORT_TICKS ticks in mode 3.
- R4: A watchdog pulse, a wake-up pulse or a low clear pin starts the sequence from a zero count. This holds while the core runs and also during a sequence that is already counting.
- R5: While `mclr_n_i` is low, the count stays at zero and reset stays high. After release, the full delay is counted.
- R6: When brown-out detection is enabled, `bod_raw_i` passes through two flops before it is used. While the synchronized flag is high, reset is held and ticks are not counted. After the flag falls, the full delay runs again, and this also applies when the brown-out arrives mid-count.
- R7: Power-on reset clears the brown-out enable bit. While the bit is clear, `bod_raw_i` has no effect. A cycle with `boden_we_i` high loads `boden_wdata_i` into the bit.
- R8: `cause_o` holds the code of the event that last started a sequence: 1 power-on, 2 brown-out, 3 clear pin, 4 watchdog, 5 wake-up. It updates in the cycle the sequence starts and holds afterwards.
- R9: When sources coincide, the cause and action priority is brown-out, then clear pin, then watchdog, then wake-up. Power-on overrides all of them.
- R10: A tick counts on a rising edge of `tick_i` only. A tick held high for many clocks counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| mclr_n_i | input | 1 | External clear pin, active low |
| wdt_to_i | input | 1 | Watchdog timeout pulse |
| wake_i | input | 1 | Wake-up on pin change pulse |
| bod_raw_i | input | 1 | Unsynchronized brown-out comparator flag |
| tick_i | input | 1 | Internal oscillator tick, counted on rising edges |
| osc_mode_i | input | 2 | Oscillator mode: 0, 1, 2 crystal-type, 3 RC |
| boden_we_i | input | 1 | Write strobe for the brown-out enable bit |
| boden_wdata_i | input | 1 | Value written to the brown-out enable bit |
| core_rst_o | output | 1 | Core reset, active high |
| cause_o | output | 3 | Last reset cause code |

## Verification
The bench sweeps all four oscillator modes for a power-on sequence and for a watchdog-started sequence. This separates the first-sequence rule from the RC short-delay rule, and each count is probed one tick before the limit and at the limit. The clear pin and brown-out are held while ticks arrive, which shows the count stays frozen. A brown-out injected mid-count shows that the full delay restarts and does not resume. Coincident events in every relevant pair fix the priority order. A stuck-high tick and a disabled brown-out enable show which inputs must be ignored.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE_RUN = 2'd0,
        ST_HOLD_BOD = 2'd1,
        ST_COUNTING = 2'd2
    } rdt_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_POR  = 3'd1,
        CAUSE_BOR  = 3'd2,
        CAUSE_MCLR = 3'd3,
        CAUSE_WDT  = 3'd4,
        CAUSE_WAKE = 3'd5
    } rdt_cause_e;

    localparam logic [1:0] OSC_MODE_RC = 2'd3;

endpackage

// File: rtl/rdt_sync2.sv
module rdt_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rdt_tick_edge.sv
module rdt_tick_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic rise_o
);
    logic tick_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= tick_i;
    end

    assign rise_o = tick_i & ~tick_q;
endmodule

// File: rtl/rdt_event_arb.sv
module rdt_event_arb
    import rdt_pkg::*;
(
    input  logic       bod_act_i,
    input  logic       mclr_low_i,
    input  logic       wdt_i,
    input  logic       wake_i,
    output logic       hit_o,
    output rdt_cause_e cause_o
);
    always_comb begin
        hit_o   = 1'b1;
        cause_o = CAUSE_NONE;
        if (bod_act_i)       cause_o = CAUSE_BOR;
        else if (mclr_low_i) cause_o = CAUSE_MCLR;
        else if (wdt_i)      cause_o = CAUSE_WDT;
        else if (wake_i)     cause_o = CAUSE_WAKE;
        else                 hit_o   = 1'b0;
    end
endmodule

// File: rtl/rst_delay_seq.sv
module rst_delay_seq
    import rdt_pkg::*;
#(
    parameter int LONG_TICKS  = 18000,
    parameter int SHORT_TICKS = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       mclr_n_i,
    input  logic       wdt_to_i,
    input  logic       wake_i,
    input  logic       bod_raw_i,
    input  logic       tick_i,
    input  logic [1:0] osc_mode_i,
    input  logic       boden_we_i,
    input  logic       boden_wdata_i,
    output logic       core_rst_o,
    output logic [2:0] cause_o
);
    localparam int CW = $clog2(LONG_TICKS + 1);
    localparam logic [CW:0] LONG_LIM  = (CW+1)'(LONG_TICKS);
    localparam logic [CW:0] SHORT_LIM = (CW+1)'(SHORT_TICKS);

    typedef struct packed {
        rdt_state_e      state;
        logic [CW-1:0]   cnt;
        logic            boden;
        logic            after_por;
        rdt_cause_e      cause;
    } regs_t;

    regs_t r_d, r_q;

    logic       bod_sync;
    logic       tick_rise;
    logic       bod_act;
    logic       ev_hit;
    rdt_cause_e ev_cause;
    logic [CW:0] lim;
    logic [CW:0] cnt_inc;

    rdt_sync2 #(.STAGES(SYNC_STAGES)) u_bod_sync (
        .clk (clk),
        .rst (por_i),
        .d_i (bod_raw_i),
        .q_o (bod_sync)
    );

    rdt_tick_edge u_tick (
        .clk    (clk),
        .rst    (por_i),
        .tick_i (tick_i),
        .rise_o (tick_rise)
    );

    assign bod_act = r_q.boden & bod_sync;

    rdt_event_arb u_arb (
        .bod_act_i  (bod_act),
        .mclr_low_i (~mclr_n_i),
        .wdt_i      (wdt_to_i),
        .wake_i     (wake_i),
        .hit_o      (ev_hit),
        .cause_o    (ev_cause)
    );

    always_comb begin
        r_d     = r_q;
        lim     = (r_q.after_por && osc_mode_i == OSC_MODE_RC) ? SHORT_LIM : LONG_LIM;
        cnt_inc = {1'b0, r_q.cnt} + 1'b1;

        if (boden_we_i) r_d.boden = boden_wdata_i;

        case (r_q.state)
            ST_HOLD_BOD: begin
                r_d.cnt = '0;
                if (!bod_act) r_d.state = ST_COUNTING;
            end
            ST_IDLE_RUN, ST_COUNTING: begin
                if (ev_hit) begin
                    r_d.cnt   = '0;
                    r_d.cause = ev_cause;
                    r_d.state = (ev_cause == CAUSE_BOR) ? ST_HOLD_BOD : ST_COUNTING;
                end else if (r_q.state == ST_COUNTING && tick_rise) begin
                    if (cnt_inc >= lim) begin
                        r_d.state     = ST_IDLE_RUN;
                        r_d.cnt       = '0;
                        r_d.after_por = 1'b1;
                    end else begin
                        r_d.cnt = cnt_inc[CW-1:0];
                    end
                end
            end
            default: r_d.state = ST_COUNTING;
        endcase
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            r_q.state     <= ST_COUNTING;
            r_q.cnt       <= '0;
            r_q.boden     <= 1'b0;
            r_q.after_por <= 1'b0;
            r_q.cause     <= CAUSE_POR;
        end else begin
            r_q <= r_d;
        end
    end

    logic [1:0]    st_cur;
    logic [CW-1:0] cnt_cur;
    logic          boden_cur;
    assign st_cur    = r_q.state;
    assign cnt_cur   = r_q.cnt;
    assign boden_cur = r_q.boden;

    assign core_rst_o = (r_q.state != ST_IDLE_RUN);
    assign cause_o    = r_q.cause;
endmodule

// File: rtl/rdt_chk.sv
module rdt_chk #(
    parameter int LONG_TICKS = 18000,
    parameter int CW         = 15
) (
    input logic          clk,
    input logic          por_i,
    input logic          mclr_n_i,
    input logic          wdt_to_i,
    input logic          wake_i,
    input logic          tick_rise,
    input logic [1:0]    st_cur,
    input logic [CW-1:0] cnt_cur,
    input logic          boden_cur,
    input logic          core_rst_o,
    input logic [2:0]    cause_o
);
    AST_CNT_BELOW_LONG: assert property (@(posedge clk) disable iff (por_i)
        32'(cnt_cur) < LONG_TICKS); // R1
    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (por_i)
        $fell(core_rst_o) |-> $past(tick_rise)); // R1
    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (por_i)
        !mclr_n_i |=> (core_rst_o && cnt_cur == '0)); // R5
    AST_WDT_RESTARTS: assert property (@(posedge clk) disable iff (por_i)
        wdt_to_i |=> (core_rst_o && cnt_cur == '0)); // R4
    AST_WAKE_RESTARTS: assert property (@(posedge clk) disable iff (por_i)
        wake_i |=> core_rst_o); // R4
    AST_HOLD_NEEDS_EN: assert property (@(posedge clk) disable iff (por_i)
        (st_cur == 2'd1) |-> $past(boden_cur)); // R7
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (por_i)
        (st_cur == 2'd1) |-> cnt_cur == '0); // R6
    AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (por_i)
        (cause_o >= 3'd1 && cause_o <= 3'd5)); // R8
endmodule

bind rst_delay_seq rdt_chk #(.LONG_TICKS(LONG_TICKS), .CW(CW)) u_rdt_chk (
    .clk        (clk),
    .por_i      (por_i),
    .mclr_n_i   (mclr_n_i),
    .wdt_to_i   (wdt_to_i),
    .wake_i     (wake_i),
    .tick_rise  (tick_rise),
    .st_cur     (st_cur),
    .cnt_cur    (cnt_cur),
    .boden_cur  (boden_cur),
    .core_rst_o (core_rst_o),
    .cause_o    (cause_o)
);

// File: tb/tb_rst_delay_seq.sv
module tb_rst_delay_seq;
    localparam int LT = 7;
    localparam int ST = 3;

    logic clk = 1'b0;
    logic por = 1'b1, mclr_n = 1'b1, wdt = 1'b0, wake = 1'b0, bod = 1'b0, tick = 1'b0;
    logic [1:0] mode = 2'd0;
    logic we = 1'b0, wdat = 1'b0;
    logic core_rst;
    logic [2:0] cause;
    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    rst_delay_seq #(.LONG_TICKS(LT), .SHORT_TICKS(ST)) dut (
        .clk(clk), .por_i(por), .mclr_n_i(mclr_n), .wdt_to_i(wdt), .wake_i(wake),
        .bod_raw_i(bod), .tick_i(tick), .osc_mode_i(mode), .boden_we_i(we),
        .boden_wdata_i(wdat), .core_rst_o(core_rst), .cause_o(cause));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic do_por();
        por = 1'b1; cyc(2); por = 1'b0; cyc(1);
    endtask

    task automatic pulse_wdt();
        wdt = 1'b1; @(negedge clk); wdt = 1'b0;
    endtask

    // runs n-1 ticks, expects reset high, then one more, expects release
    task automatic period(input string req, input int n);
        ticks(n - 1); chk(req, core_rst, 1);
        ticks(1);     chk(req, core_rst, 0);
    endtask

    initial begin
        cyc(1);
        chk("R8 reset cause", cause, 1);
        chk("R1 reset state", core_rst, 1);
        por = 1'b0; cyc(1);
        // R2: first sequence long in every mode
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m); do_por();
            chk("R8 por cause", cause, 1);
            period("R2 first long", LT);
        end
        // R3: later sequences mode-dependent
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m); pulse_wdt(); cyc(1);
            chk("R8 wdt cause", cause, 4);
            period("R3 later period", (m == 3) ? ST : LT);
        end
        mode = 2'd0;
        // R4: wake, and restart mid-count
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        chk("R8 wake cause", cause, 5);
        ticks(4); pulse_wdt();
        period("R4 restart mid-count", LT);
        // R10: held tick counts once
        pulse_wdt();
        tick = 1'b1; cyc(20); tick = 1'b0; cyc(1);
        period("R10 held tick", LT - 1);
        // R5: clear pin held
        mclr_n = 1'b0; cyc(1);
        chk("R8 mclr cause", cause, 3);
        ticks(12); chk("R5 held low", core_rst, 1);
        mclr_n = 1'b1; cyc(1);
        period("R5 after release", LT);
        // R9 priorities
        wdt = 1'b1; wake = 1'b1; @(negedge clk); wdt = 1'b0; wake = 1'b0;
        chk("R9 wdt over wake", cause, 4);
        mclr_n = 1'b0; wdt = 1'b1; @(negedge clk); wdt = 1'b0; mclr_n = 1'b1;
        chk("R9 mclr over wdt", cause, 3);
        ticks(LT);
        // R7: brown-out disabled after POR
        bod = 1'b1; cyc(5);
        chk("R7 bod ignored", core_rst, 0);
        bod = 1'b0; cyc(3);
        we = 1'b1; wdat = 1'b1; @(negedge clk); we = 1'b0;
        // R6: brown-out hold and recovery
        bod = 1'b1; cyc(3);
        chk("R6 bod holds", core_rst, 1);
        chk("R8 bor cause", cause, 2);
        ticks(10); bod = 1'b0; cyc(4);
        period("R6 full after recovery", LT);
        // R6 mid-count, RC mode short
        mode = 2'd3; pulse_wdt(); ticks(2);
        bod = 1'b1; cyc(4); bod = 1'b0; cyc(4);
        period("R6 mid-count restart", ST);
        // R9: brown-out over clear pin
        mclr_n = 1'b0; bod = 1'b1; cyc(4);
        chk("R9 bor over mclr", cause, 2);
        mclr_n = 1'b1; bod = 1'b0; cyc(4);
        ticks(LT);
        // R7: POR clears enable
        mode = 2'd0; do_por(); ticks(LT);
        bod = 1'b1; cyc(5);
        chk("R7 enable cleared by por", core_rst, 0);
        bod = 1'b0; cyc(2);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule